// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Transaction Master

This block drives a two-wire serial bus as its only master and carries out whole EEPROM transactions on behalf of on-chip logic. A client gives one command with four fields: an operation code, the three strap bits that select the target device, a word address and a length. The block then runs the complete bus sequence on its own. Bytes to be written come in on a valid/ready stream. Bytes that are read go out on a valid-only stream.

SCL is a push-pull output. SDA is open-drain: `sda_oe` high means the block pulls the line low, and `sda_in` returns the level seen on the wire.

One SCL period is four phases. Each phase lasts `DIV` clocks, and `DIV` must be at least 2.

Reads first send a dummy write that loads the word address, then chain into a read with a repeated start. After every write the block probes the device with its address until the device answers again, so a completed command means that the device's internal write has finished.

Top module: `eeprom_bus_master`

## Requirements
- R1: Out of reset, and between commands, SCL is high, SDA is released, `cmd_ready` is high, and `done` and all error flags are low.
- R2: Every device address byte goes out after a start, most significant bit first, as `1010`, then the three strap bits, then R/W (0 for write, 1 for read).
- R3: Op 0 (byte write) sends the address byte with R/W = 0, then the word address, then one byte from the write stream, then a stop.
- R4: Op 1 (page write) sends `cmd_len` bytes after the word address and before the stop. The bytes are taken in stream order, one per `wr_valid`/`wr_ready` handshake, and `wr_ready` is only high while SCL is low.
- R5: Two commands are rejected: op 1 with `cmd_len` of 0 or above `PAGE_MAX` (8), and op 3 with `cmd_len` of 0. A rejected command raises `err_len` and `done` in the cycle after it is accepted, and SCL never falls.
- R6: Op 2 (random read) sends a dummy write (address byte, word address), a repeated start, and the address byte with R/W = 1. It then receives one byte, leaves SDA high on its ninth bit, stops, and presents the byte with a one-cycle `rd_valid`.
- R7: Op 3 (sequential read) receives `cmd_len` bytes. It acknowledges every byte except the last, leaves SDA high on the last byte, and then stops. Each byte appears once on `rd_valid`.
- R8: After the stop of a write, the block repeats start, address byte (R/W = 0) and stop until the device acknowledges the address. Only then does it raise `done`.
- R9: If `POLL_LIMIT` probes in a row are not acknowledged, the command ends with `err_timeout` and `done`, and no further probe is sent.
- R10: A missing acknowledge on the address byte or on the word address ends the command at once with a stop and raises `err_nack`. No data byte is sent and no probing follows.
- R11: Inside a byte, SDA changes only while SCL is low. SDA changes while SCL is high only to form a start or a stop.
- R12: `done` is high for exactly one cycle per command. Consecutive SCL rising edges within a byte are 4·`DIV` clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 2 | 0 byte write, 1 page write, 2 random read, 3 sequential read |
| cmd_strap | input | 3 | Device select bits placed in the address byte |
| cmd_addr | input | 8 | Word address |
| cmd_len | input | LEN_W | Byte count for page write and sequential read |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream byte present |
| wr_ready | output | 1 | Block takes the write stream byte this cycle |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| scl | output | 1 | Serial clock |
| sda_oe | output | 1 | High pulls SDA low |
| sda_in | input | 1 | Sampled SDA wire level |
| done | output | 1 | One-cycle completion pulse |
| err_nack | output | 1 | Address or word address not acknowledged; held until next accept |
| err_len | output | 1 | Length rejected; held until next accept |
| err_timeout | output | 1 | Polling limit reached; held until next accept |

## Verification
The embedded properties watch four things on every clock: that SDA stays still while SCL is high inside a byte, that `done` never lasts two cycles, that the write stream is only drawn while SCL is low, and that the probe counter never passes its limit. They also tie each error flag to the event that causes it: an over-long page write, an unacknowledged address, or a completion after too many probes. Whether the bytes on the wire form the right sequence can only be shown by the bench's device model on the far side of the bus. That covers the repeated start before a read, the number of probes before the device answers again, the withheld acknowledge on the final read byte, and page-local address wrap in stored data.

// File: rtl/eeprom_bus_master.sv
module eeprom_bus_master #(
  parameter int DIV        = 125,
  parameter int PAGE_MAX   = 8,
  parameter int POLL_LIMIT = 2000,
  parameter int LEN_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [2:0]       cmd_strap,
  input  logic [7:0]       cmd_addr,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             scl,
  output logic             sda_oe,
  input  logic             sda_in,
  output logic             done,
  output logic             err_nack,
  output logic             err_len,
  output logic             err_timeout
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int PW = $clog2(POLL_LIMIT + 1);

  typedef enum logic [3:0] {
    IDLE, START, DEVW, WADDR, WDATA, RSTART, DEVR, RDATA, STOP, PSTART, PDEV, PSTOP
  } st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [1:0]       ph;
  logic [3:0]       bitn;
  logic [7:0]       sh;
  logic             ldd, ackd, pok, abort_r, is_rd;
  logic [2:0]       strap_r;
  logic [7:0]       addr_r;
  logic [LEN_W-1:0] left;
  logic [PW-1:0]    polls;

  wire k_start = (st == START) || (st == RSTART) || (st == PSTART);
  wire k_stop  = (st == STOP) || (st == PSTOP);
  wire k_tx    = (st == DEVW) || (st == WADDR) || (st == WDATA) || (st == DEVR) || (st == PDEV);
  wire k_rx    = (st == RDATA);
  wire busy    = (st != IDLE);
  wire run     = busy && (ldd || !k_tx);
  wire tick    = run && (cnt == CW'(DIV - 1));
  wire ph_end  = tick && (ph == 2'd3);
  wire is_last = (left == LEN_W'(1));
  wire accept  = cmd_valid && cmd_ready;
  wire bad_len = ((cmd_op == 2'd1) && (cmd_len == '0 || int'(cmd_len) > PAGE_MAX)) ||
                 ((cmd_op == 2'd3) && (cmd_len == '0));

  assign cmd_ready = !busy;
  assign wr_ready  = (st == WDATA) && !ldd;
  assign scl       = !busy || (k_stop ? (ph != 2'd0) : (ph == 2'd1 || ph == 2'd2));
  assign sda_oe    = k_start ? ph[1] :
                     k_stop  ? !ph[1] :
                     k_tx    ? (ldd && bitn != 4'd8 && !sh[7]) :
                     k_rx    ? (bitn == 4'd8 && !is_last) : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; ph <= '0; bitn <= '0; sh <= '0;
      ldd <= 1'b0; ackd <= 1'b0; pok <= 1'b0; abort_r <= 1'b0; is_rd <= 1'b0;
      strap_r <= '0; addr_r <= '0; left <= '0; polls <= '0;
      rd_data <= '0; rd_valid <= 1'b0; done <= 1'b0;
      err_nack <= 1'b0; err_len <= 1'b0; err_timeout <= 1'b0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      if (accept) begin
        err_nack <= 1'b0; err_len <= 1'b0; err_timeout <= 1'b0;
        strap_r <= cmd_strap; addr_r <= cmd_addr; is_rd <= cmd_op[1];
        left <= cmd_op[0] ? cmd_len : LEN_W'(1);
        cnt <= '0; ph <= '0; bitn <= '0; ldd <= 1'b0; abort_r <= 1'b0;
        if (bad_len) begin
          err_len <= 1'b1;
          done    <= 1'b1;
        end else begin
          st <= START;
        end
      end
      if (k_tx && !ldd) begin
        case (st)
          DEVW, PDEV: begin sh <= {4'b1010, strap_r, 1'b0}; ldd <= 1'b1; end
          DEVR:       begin sh <= {4'b1010, strap_r, 1'b1}; ldd <= 1'b1; end
          WADDR:      begin sh <= addr_r; ldd <= 1'b1; end
          default:    if (wr_valid) begin sh <= wr_data; ldd <= 1'b1; end
        endcase
      end
      if (tick) begin
        cnt <= '0;
        ph  <= ph + 2'd1;
        if (ph == 2'd2 && bitn == 4'd8) ackd <= !sda_in;
        if (ph == 2'd2 && k_rx && bitn != 4'd8) sh <= {sh[6:0], sda_in};
        if (ph == 2'd3 && k_tx && bitn != 4'd8) sh <= {sh[6:0], 1'b0};
        if (ph == 2'd3 && (k_tx || k_rx)) bitn <= (bitn == 4'd8) ? 4'd0 : bitn + 4'd1;
      end else if (run) begin
        cnt <= cnt + CW'(1);
      end
      if (ph_end && ((k_start || k_stop) || bitn == 4'd8)) begin
        ldd <= 1'b0;
        case (st)
          START:  st <= DEVW;
          RSTART: st <= DEVR;
          PSTART: st <= PDEV;
          DEVW, WADDR, DEVR: begin
            if (!ackd) begin
              err_nack <= 1'b1; abort_r <= 1'b1; st <= STOP;
            end else if (st == DEVW) st <= WADDR;
            else if (st == DEVR) st <= RDATA;
            else st <= is_rd ? RSTART : WDATA;
          end
          WDATA: begin
            if (is_last) st <= STOP;
            else left <= left - LEN_W'(1);
          end
          RDATA: begin
            rd_valid <= 1'b1;
            rd_data  <= sh;
            if (is_last) st <= STOP;
            else left <= left - LEN_W'(1);
          end
          STOP: begin
            if (!is_rd && !abort_r) begin
              st <= PSTART; polls <= '0;
            end else begin
              st <= IDLE; done <= 1'b1;
            end
          end
          PDEV: begin
            pok <= ackd; polls <= polls + PW'(1); st <= PSTOP;
          end
          PSTOP: begin
            if (pok) begin
              st <= IDLE; done <= 1'b1;
            end else if (polls == PW'(POLL_LIMIT)) begin
              st <= IDLE; done <= 1'b1; err_timeout <= 1'b1;
            end else begin
              st <= PSTART;
            end
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  // R11
  sda_in_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl && $past(scl) && (k_tx || k_rx) && $past(k_tx || k_rx)) |-> $stable(sda_oe));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R4
  wr_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_ready |-> !scl);

  // R5
  len_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op == 2'd1 && int'(cmd_len) > PAGE_MAX) |=> (done && err_len && cmd_ready));

  // R9
  poll_cap_chk: assert property (@(posedge clk) disable iff (!rst_n) polls <= PW'(POLL_LIMIT));

  // R9
  timeout_done_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(err_timeout) |-> done);

  // R10
  nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(err_nack) |-> (st == STOP));

  // R6
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> !cmd_ready);
endmodule

// File: tb/eeprom_bus_master_bench.sv
module eeprom_bus_master_bench;
  localparam int DIV = 2;
  localparam int PL  = 6;
  localparam int LW  = 4;
  localparam logic [2:0] MYSTRAP = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = '0;
  logic [2:0] cmd_strap = '0;
  logic [7:0] cmd_addr = '0;
  logic [LW-1:0] cmd_len = '0;
  logic [7:0] wr_data;
  logic wr_valid, wr_ready;
  logic [7:0] rd_data;
  logic rd_valid, scl, sda_oe, sda_in, done, err_nack, err_len, err_timeout;
  logic s_pull = 1'b0;
  wire sda_line = !(sda_oe || s_pull);
  assign sda_in = sda_line;

  logic [7:0] wq [256];
  int wn = 0, widx = 0;
  assign wr_valid = (widx < wn);
  assign wr_data  = wq[8'(widx)];

  logic [7:0] rq [256];
  int rn = 0;

  int n_chk = 0, n_bad = 0;

  eeprom_bus_master #(.DIV(DIV), .PAGE_MAX(8), .POLL_LIMIT(PL), .LEN_W(LW)) u_eeprom_bus_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_strap(cmd_strap), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .scl(scl), .sda_oe(sda_oe), .sda_in(sda_in),
    .done(done), .err_nack(err_nack), .err_len(err_len), .err_timeout(err_timeout));

  initial forever #10 clk = ~clk;

  // device model on the far side of the bus
  logic [7:0] mem [256];
  logic [7:0] dsh = '0, dtx = '0, dptr = '0, last_addr = '0;
  int rc = 0, sst = 0, busy_cnt = 0, cyc = 0, last_rise = 0;
  bit first = 0, macks = 0, wrote = 0, prev_scl = 1, prev_sda = 1;
  int n_start = 0, n_stop = 0, n_addr = 0, m_ack = 0, m_nack = 0, n_fall = 0;
  int per_bad = 0, per_n = 0;
  int busy_polls = 0;
  bit nack_word = 0;

  initial begin
    bit s, d;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    forever begin
      @(negedge clk);
      cyc++;
      s = scl; d = sda_line;
      if (s && prev_scl && prev_sda && !d) begin
        n_start++; rc = 0; sst = 1; s_pull = 1'b0;
      end else if (s && prev_scl && !prev_sda && d) begin
        n_stop++; rc = 0; sst = 0; s_pull = 1'b0;
        if (wrote) begin busy_cnt = busy_polls; wrote = 0; end
      end else if (s && !prev_scl) begin
        if (rc >= 1 && rc <= 8) begin
          per_n++;
          if (cyc - last_rise != 4 * DIV) per_bad++;
        end
        last_rise = cyc;
        if (rc < 8) dsh = {dsh[6:0], d};
        else if (rc == 8) macks = !d;
        rc++;
      end else if (!s && prev_scl) begin
        n_fall++;
        if (rc == 8) begin
          case (sst)
            1: begin
              n_addr++; last_addr = dsh;
              if (dsh[7:1] == {4'hA, MYSTRAP}) begin
                if (busy_cnt > 0) begin busy_cnt--; s_pull = 1'b0; sst = 5; end
                else begin s_pull = 1'b1; sst = dsh[0] ? 4 : 2; first = 1; end
              end else begin s_pull = 1'b0; sst = 5; end
            end
            2: if (nack_word) begin s_pull = 1'b0; sst = 5; end
               else begin dptr = dsh; s_pull = 1'b1; sst = 3; end
            3: begin
              mem[dptr] = dsh; dptr = {dptr[7:3], dptr[2:0] + 3'd1};
              wrote = 1; s_pull = 1'b1;
            end
            default: s_pull = 1'b0;
          endcase
        end else if (rc == 9) begin
          rc = 0; s_pull = 1'b0;
          if (sst == 4) begin
            if (!first) begin if (macks) m_ack++; else m_nack++; end
            if (first || macks) begin
              dtx = mem[dptr]; dptr = dptr + 8'd1; first = 0; s_pull = !dtx[7];
            end else sst = 5;
          end
        end else if (sst == 4 && rc >= 1 && rc <= 7) begin
          s_pull = !dtx[7 - rc];
        end
      end
      prev_scl = s; prev_sda = d;
    end
  end

  initial forever begin
    @(negedge clk);
    if (wr_valid && wr_ready) begin @(posedge clk); #1; widx = widx + 1; end
  end

  initial forever begin
    @(negedge clk);
    if (rd_valid) begin rq[8'(rn)] = rd_data; rn = rn + 1; end
  end

  initial begin
    repeat (195000) @(posedge clk);
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic [7:0] exp_mem [256];
  int s0, p0, a0, k0, f0, ma0, mn0, r0;

  task automatic issue(input logic [1:0] op, input logic [2:0] strap, input logic [7:0] a, input int len);
    int t;
    s0 = n_start; p0 = n_stop; a0 = n_addr; f0 = n_fall; ma0 = m_ack; mn0 = m_nack; r0 = rn;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_strap = strap; cmd_addr = a; cmd_len = LW'(len);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    t = 0;
    do begin @(negedge clk); t++; end while (!done && t < 40000);
    chk(done, "R12 done seen", int'(done), 1);
    @(negedge clk);
    chk(!done, "R12 done one cycle", int'(done), 0);
    chk(cmd_ready && scl && !sda_oe, "R1 idle lines", int'({cmd_ready, scl, sda_oe}), 6);
  endtask

  int mism;
  task automatic mem_cmp(input string req);
    mism = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) mism++;
    chk(mism == 0, req, mism, 0);
  endtask

  initial begin
    logic [7:0] a;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i * 7 + 3);
    repeat (3) @(posedge clk);
    #1;
    chk(cmd_ready && scl && !sda_oe, "R1 reset lines", int'({cmd_ready, scl, sda_oe}), 6);
    chk(!done && !err_nack && !err_len && !err_timeout, "R1 reset flags",
        int'({done, err_nack, err_len, err_timeout}), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R3 / R8: byte writes with 0..3 busy probes
    for (int k = 0; k < 4; k++) begin
      busy_polls = k;
      a = 8'(k * 37 + 5);
      wq[8'(wn)] = 8'(k * 29 + 17); exp_mem[a] = 8'(k * 29 + 17); wn++;
      issue(2'd0, MYSTRAP, a, 0);
      chk(!err_nack && !err_timeout && !err_len, "R3 flags", int'({err_nack, err_timeout, err_len}), 0);
      chk(n_start - s0 == 2 + k, "R8 starts incl probes", n_start - s0, 2 + k);
      chk(n_stop - p0 == 2 + k, "R8 stops incl probes", n_stop - p0, 2 + k);
      chk(n_addr - a0 == 2 + k, "R8 address bytes", n_addr - a0, 2 + k);
      chk(last_addr == {4'hA, MYSTRAP, 1'b0}, "R2 probe address byte", int'(last_addr), int'({4'hA, MYSTRAP, 1'b0}));
      mem_cmp("R3 stored byte");
    end

    // R4: page writes, every length, offset forcing page wrap
    busy_polls = 1;
    for (int len = 1; len <= 8; len++) begin
      a = 8'(8'h40 + len * 8 + (len + 2) % 8);
      for (int i = 0; i < len; i++) begin
        wq[8'(wn)] = 8'(len * 11 + i * 3 + 1);
        exp_mem[{a[7:3], 3'(a[2:0] + 3'(i))}] = 8'(len * 11 + i * 3 + 1);
        wn++;
      end
      issue(2'd1, MYSTRAP, a, len);
      chk(widx == wn, "R4 stream consumed", widx, wn);
      chk(!err_len && !err_nack, "R4 flags", int'({err_len, err_nack}), 0);
      chk(n_start - s0 == 3, "R8 page write probes", n_start - s0, 3);
      mem_cmp("R4 page contents");
    end
    busy_polls = 0;

    // R5: rejected lengths
    issue(2'd1, MYSTRAP, 8'h10, 9);
    chk(err_len && n_fall == f0, "R5 page len 9", int'(err_len), 1);
    issue(2'd1, MYSTRAP, 8'h10, 0);
    chk(err_len && n_fall == f0, "R5 page len 0", int'(err_len), 1);
    issue(2'd3, MYSTRAP, 8'h10, 0);
    chk(err_len && n_fall == f0, "R5 seq len 0", int'(err_len), 1);
    chk(widx == wn, "R5 no stream drawn", widx, wn);

    // R6: random reads
    for (int k = 0; k < 8; k++) begin
      a = 8'(k * 41 + 2);
      issue(2'd2, MYSTRAP, a, 0);
      chk(rn - r0 == 1, "R6 one byte", rn - r0, 1);
      chk(rq[8'(r0)] == exp_mem[a], "R6 data", int'(rq[8'(r0)]), int'(exp_mem[a]));
      chk(n_start - s0 == 2 && n_stop - p0 == 1, "R6 repeated start", n_start - s0, 2);
      chk(m_nack - mn0 == 1 && m_ack == ma0, "R6 final nack", m_nack - mn0, 1);
      chk(last_addr == {4'hA, MYSTRAP, 1'b1}, "R2 read address byte", int'(last_addr), int'({4'hA, MYSTRAP, 1'b1}));
    end

    // R7: sequential reads across the top of the array
    for (int len = 1; len <= 15; len++) begin
      a = 8'hF5;
      issue(2'd3, MYSTRAP, a, len);
      chk(rn - r0 == len, "R7 byte count", rn - r0, len);
      mism = 0;
      for (int i = 0; i < len; i++) if (rq[8'(r0 + i)] !== exp_mem[8'(a + 8'(i))]) mism++;
      chk(mism == 0, "R7 data", mism, 0);
      chk(m_ack - ma0 == len - 1, "R7 acks", m_ack - ma0, len - 1);
      chk(m_nack - mn0 == 1, "R7 last nack", m_nack - mn0, 1);
    end

    // R10: wrong strap, then word address refused
    issue(2'd0, 3'b010, 8'h33, 0);
    wq[8'(wn)] = 8'hEE; wn++;
    chk(err_nack && n_start - s0 == 1 && n_stop - p0 == 1, "R10 strap mismatch", int'(err_nack), 1);
    nack_word = 1;
    issue(2'd0, MYSTRAP, 8'h33, 0);
    nack_word = 0;
    chk(err_nack && n_start - s0 == 1 && n_stop - p0 == 1, "R10 word nack", int'(err_nack), 1);
    chk(widx == wn - 1, "R10 no data sent", widx, wn - 1);
    mem_cmp("R10 memory untouched");
    wn--;

    // R9: polling limit, then leftover busy probes refused on reads
    busy_polls = PL + 2;
    wq[8'(wn)] = 8'h5C; exp_mem[8'h77] = 8'h5C; wn++;
    issue(2'd0, MYSTRAP, 8'h77, 0);
    chk(err_timeout, "R9 timeout flag", int'(err_timeout), 1);
    chk(n_addr - a0 == 1 + PL, "R9 probe count", n_addr - a0, 1 + PL);
    busy_polls = 0;
    issue(2'd2, MYSTRAP, 8'h77, 0);
    chk(err_nack && rn == r0, "R10 busy address nack", int'(err_nack), 1);
    issue(2'd2, MYSTRAP, 8'h77, 0);
    chk(err_nack && !err_timeout, "R10 busy address nack 2", int'(err_nack), 1);
    issue(2'd2, MYSTRAP, 8'h77, 0);
    chk(!err_nack && rq[8'(r0)] == 8'h5C, "R9 write landed", int'(rq[8'(r0)]), 8'h5C);

    chk(per_n > 0 && per_bad == 0, "R12 SCL period", per_bad, 0);
    chk(per_n > 0 && per_bad == 0, "R11 bit framing", per_n > 0 ? 1 : 0, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule